// File: doc/BRIEF.md
# Timestamp and Pulse-Tick Timer Unit

This block holds a wide free-running time base. It counts enable pulses that mark each tick of a crystal reference, normally 19.2 MHz. From that one count it derives three coarse timestamps, called logging, tag and NAT. Each is the count shifted right by a programmable number of bits and cut to the output width. The logging stamp can instead show a legacy counter that advances once per millisecond's worth of reference pulses.

The same reference pulses feed a gated prescaler. It divides by its programmed value plus one and produces a common timer tick. With a value of 191, a 19.2 MHz reference gives a 100 kHz tick. A set of pulse generators counts these common ticks. Each generator emits a one-cycle strobe at a granularity chosen by a 3-bit code, from 10 µs up to 100 ms. Downstream timers use these strobes.

Configuration arrives over a simple write port with three words: stamp shifts, divider, and granularities. Software clears the divider word before it changes the rate, writes the new value with the enable low, and then sets the enable.

Top module: `tstamp_tick_unit`

## Requirements
- R1: `raw_time` increments by one on each clock cycle in which `ref_pulse` is high, holds its value otherwise, and wraps to zero after its all-ones value.
- R2: Each shifted stamp equals the low OUT_W bits of `raw_time` shifted right by its shift field, taken combinationally from the live count. Word 0 holds the fields: logging shift in bits [5:0], tag shift in bits [11:6], NAT shift in bits [17:12].
- R3: Bit 18 of word 0 selects the source of `log_stamp`. When the bit is 1, `log_stamp` is the shifted time base. When it is 0, `log_stamp` is a legacy count that advances once every LEGACY_REFS reference pulses.
- R4: Word 1 carries the divider value in bits [DIV_W-1:0] and the enable in bit 31. While enabled, `common_tick` pulses once every value+1 reference pulses. Each pulse comes one cycle after the reference pulse that closes the period.
- R5: While the divider enable is low, `common_tick` stays low.
- R6: Writing word 1 with the enable low clears the prescale count. After the enable is then written high, with a reference pulse in every cycle, the first `common_tick` appears value+1 cycles after that write.
- R7: Generator i reads its granularity code from word 2, bits [4i+2:4i]. It pulses `gen_tick[i]` once every N common ticks, one cycle after the N-th tick. N is 1, 2, 5, 10, 100, 1000 and 10000 for codes 0 to 6, and code 7 acts as code 6.
- R8: A word-2 write that changes a generator's code restarts that generator. Its next strobe comes exactly N common ticks later. Generators whose code did not change keep their phase.
- R9: A synchronous active-high reset clears the time base, the legacy count, the divider, the generators and all configuration. The divider is left disabled and no strobes are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle enable per reference tick |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Word select: 0 stamps, 1 divider, 2 granularity |
| wr_data | input | DATA_W | Write data |
| raw_time | output | TS_W | Live raw time base |
| log_stamp | output | OUT_W | Logging stamp (shifted or legacy) |
| tag_stamp | output | OUT_W | Tag stamp |
| nat_stamp | output | OUT_W | NAT stamp |
| common_tick | output | 1 | Divided common timer tick |
| gen_tick | output | NUM_GEN | Per-generator granularity strobes |

## Verification
The bench measures the first-tick latency after a re-enable that follows a clearing write. A design that kept the old prescale count would tick early. The bench also checks that no ticks appear while the divider is disabled, including in the cycle right after the disable write. A design that dropped the gating would leak one stray tick there. Granularity changes go in mid-run so that a restart can be timed. A generator that was not restarted would strobe at its old phase, and one whose code did not change but was restarted anyway would lose its phase. A narrow second instance drives the time base through wrap, and the shifted stamps are compared against the raw count at the ports.

// File: rtl/tstu_pkg.sv
package tstu_pkg;
   localparam int GRAN_CODE_W  = 3;
   localparam int GEN_TERM_MAX = 10000;
   localparam int GEN_CNT_W    = $clog2(GEN_TERM_MAX);

   // Common ticks per strobe for each granularity code.
   function automatic logic [GEN_CNT_W-1:0] gran_terminal(input logic [GRAN_CODE_W-1:0] code);
      logic [GEN_CNT_W-1:0] t;
      case (code)
         3'd0:    t = GEN_CNT_W'(1);
         3'd1:    t = GEN_CNT_W'(2);
         3'd2:    t = GEN_CNT_W'(5);
         3'd3:    t = GEN_CNT_W'(10);
         3'd4:    t = GEN_CNT_W'(100);
         3'd5:    t = GEN_CNT_W'(1000);
         default: t = GEN_CNT_W'(GEN_TERM_MAX);
      endcase
      return t;
   endfunction
endpackage

// File: rtl/tstu_timebase.sv
module tstu_timebase #(
   parameter int TS_W        = 56,
   parameter int OUT_W       = 32,
   parameter int LEGACY_REFS = 19200
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_pulse,
   output logic [TS_W-1:0]  raw_o,
   output logic [OUT_W-1:0] legacy_o
);
   localparam int LPRE_W = $clog2(LEGACY_REFS + 1);

   logic [LPRE_W-1:0] lpre_q;

   if (LEGACY_REFS < 1) begin : g_bad_legacy
      $error("LEGACY_REFS must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         raw_o    <= '0;
         lpre_q   <= '0;
         legacy_o <= '0;
      end else if (ref_pulse) begin
         raw_o <= raw_o + 1'b1;
         if (lpre_q == LPRE_W'(LEGACY_REFS - 1)) begin
            lpre_q   <= '0;
            legacy_o <= legacy_o + 1'b1;
         end else begin
            lpre_q <= lpre_q + 1'b1;
         end
      end
   end

   assert_raw_step_R1: assert property (@(posedge clk) disable iff (rst)
      ref_pulse |=> raw_o == $past(raw_o) + 1'b1);
   assert_raw_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !ref_pulse |=> $stable(raw_o));
   assert_legacy_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !ref_pulse |=> $stable(legacy_o));
endmodule

// File: rtl/tstu_divider.sv
module tstu_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_pulse,
   input  logic             en_i,
   input  logic [DIV_W-1:0] val_i,
   input  logic             clr_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] pre_q;
   logic             wrap;

   assign wrap = (pre_q >= val_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= en_i && ref_pulse && !clr_i && wrap;
         if (clr_i)
            pre_q <= '0;
         else if (en_i && ref_pulse)
            pre_q <= wrap ? '0 : pre_q + 1'b1;
      end
   end

   assert_tick_gated_R5: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> !tick_o);
   assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (pre_q == '0) && !tick_o);
   assert_tick_needs_ref_R4: assert property (@(posedge clk) disable iff (rst)
      !ref_pulse |=> !tick_o);
endmodule

// File: rtl/tstu_pulse_gen.sv
module tstu_pulse_gen
   import tstu_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   tick_i,
   input  logic [GRAN_CODE_W-1:0] code_i,
   input  logic                   restart_i,
   output logic                   strobe_o
);
   logic [GEN_CNT_W-1:0] cnt_q;
   logic [GEN_CNT_W-1:0] term;

   assign term = gran_terminal(code_i);

   always_ff @(posedge clk) begin
      if (rst || restart_i) begin
         cnt_q    <= '0;
         strobe_o <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q >= term - 1'b1) begin
            cnt_q    <= '0;
            strobe_o <= 1'b1;
         end else begin
            cnt_q    <= cnt_q + 1'b1;
            strobe_o <= 1'b0;
         end
      end else begin
         strobe_o <= 1'b0;
      end
   end

   assert_strobe_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
      strobe_o |-> $past(tick_i));
   assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
      restart_i || cnt_q < term);
   assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
      restart_i |=> cnt_q == '0 && !strobe_o);
endmodule

// File: rtl/tstamp_tick_unit.sv
module tstamp_tick_unit
   import tstu_pkg::*;
#(
   parameter int TS_W        = 56,
   parameter int OUT_W       = 32,
   parameter int DIV_W       = 16,
   parameter int LEGACY_REFS = 19200,
   parameter int NUM_GEN     = 3,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ref_pulse,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [TS_W-1:0]    raw_time,
   output logic [OUT_W-1:0]   log_stamp,
   output logic [OUT_W-1:0]   tag_stamp,
   output logic [OUT_W-1:0]   nat_stamp,
   output logic               common_tick,
   output logic [NUM_GEN-1:0] gen_tick
);
   localparam int SH_W      = 6;
   localparam int NUM_STAMP = 3;
   localparam int SEL_BIT   = SH_W * NUM_STAMP;
   localparam int EN_BIT    = DATA_W - 1;
   localparam int GFIELD_W  = 4;
   localparam logic [ADDR_W-1:0] ADDR_STAMP = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] ADDR_DIV   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_GRAN  = ADDR_W'(2);

   if (OUT_W > TS_W) begin : g_bad_out
      $error("OUT_W must not exceed TS_W");
   end
   if (DIV_W >= DATA_W) begin : g_bad_div
      $error("DIV_W must leave room for the enable bit");
   end
   if (GFIELD_W * NUM_GEN > DATA_W || SEL_BIT >= DATA_W) begin : g_bad_fields
      $error("configuration fields do not fit in DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [SH_W-1:0]        shift_q [NUM_STAMP];
   logic                   log_sel_q;
   logic [DIV_W-1:0]       div_val_q;
   logic                   div_en_q;
   logic [GRAN_CODE_W-1:0] gran_q  [NUM_GEN];
   logic [NUM_GEN-1:0]     restart;
   logic [OUT_W-1:0]       stamp   [NUM_STAMP];
   logic [OUT_W-1:0]       legacy;
   logic                   wr_stamp, wr_div, wr_gran, div_clr;

   assign wr_stamp = wr_en && (wr_addr == ADDR_STAMP);
   assign wr_div   = wr_en && (wr_addr == ADDR_DIV);
   assign wr_gran  = wr_en && (wr_addr == ADDR_GRAN);
   assign div_clr  = wr_div && !wr_data[EN_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         log_sel_q <= 1'b0;
         div_val_q <= '0;
         div_en_q  <= 1'b0;
      end else begin
         if (wr_stamp) log_sel_q <= wr_data[SEL_BIT];
         if (wr_div) begin
            div_val_q <= wr_data[DIV_W-1:0];
            div_en_q  <= wr_data[EN_BIT];
         end
      end
   end

   tstu_timebase #(.TS_W(TS_W), .OUT_W(OUT_W), .LEGACY_REFS(LEGACY_REFS)) timebase_i (
      .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .raw_o(raw_time), .legacy_o(legacy));

   for (genvar s = 0; s < NUM_STAMP; s++) begin : g_stamp
      logic [TS_W-1:0] shifted;
      always_ff @(posedge clk) begin
         if (rst)           shift_q[s] <= '0;
         else if (wr_stamp) shift_q[s] <= wr_data[SH_W*s +: SH_W];
      end
      assign shifted  = raw_time >> shift_q[s];
      assign stamp[s] = shifted[OUT_W-1:0];
   end

   assign log_stamp = log_sel_q ? stamp[0] : legacy;
   assign tag_stamp = stamp[1];
   assign nat_stamp = stamp[2];

   tstu_divider #(.DIV_W(DIV_W)) divider_i (
      .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .en_i(div_en_q),
      .val_i(div_val_q), .clr_i(div_clr), .tick_o(common_tick));

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      assign restart[g] = wr_gran &&
                          (wr_data[GFIELD_W*g +: GRAN_CODE_W] != gran_q[g]);
      always_ff @(posedge clk) begin
         if (rst)          gran_q[g] <= '0;
         else if (wr_gran) gran_q[g] <= wr_data[GFIELD_W*g +: GRAN_CODE_W];
      end
      tstu_pulse_gen gen_i (
         .clk(clk), .rst(rst), .tick_i(common_tick), .code_i(gran_q[g]),
         .restart_i(restart[g]), .strobe_o(gen_tick[g]));
   end

   assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      !div_en_q && !common_tick |=> !common_tick);
   assert_reset_state_R9: assert property (@(posedge clk)
      $past(rst) |-> raw_time == '0 && !common_tick && gen_tick == '0);
endmodule

// File: tb/tstamp_tick_unit_tb.sv
module tstamp_tick_unit_tb_top;
   localparam int OUT_W = 32;
   localparam int LEG   = 16;
   localparam int NG    = 3;
   localparam longint unsigned MASK56 = (64'd1 << 56) - 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst = 1'b1, ref_pulse = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [55:0] raw_time;
   logic [OUT_W-1:0] log_stamp, tag_stamp, nat_stamp;
   logic common_tick;
   logic [NG-1:0] gen_tick;
   logic [7:0] raw_w, log_w, tag_w, nat_w;
   logic tick_w;
   logic [NG-1:0] gen_w;

   tstamp_tick_unit #(.LEGACY_REFS(LEG)) dut_i (
      .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .raw_time(raw_time), .log_stamp(log_stamp), .tag_stamp(tag_stamp),
      .nat_stamp(nat_stamp), .common_tick(common_tick), .gen_tick(gen_tick));

   tstamp_tick_unit #(.TS_W(8), .OUT_W(8), .LEGACY_REFS(LEG)) dut_w (
      .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .raw_time(raw_w), .log_stamp(log_w), .tag_stamp(tag_w),
      .nat_stamp(nat_w), .common_tick(tick_w), .gen_tick(gen_w));

   int compared = 0, mismatched = 0, cyc = 0;
   int ref_mode = 0, ref_phase = 0;
   bit comparing = 0, wrap_seen = 0, done = 0;
   int n_tick = 0;
   int n_gen [NG];
   string tick_req = "R4";

   // behavioural reference model
   longint unsigned m_raw;
   int m_raw_w, m_lpre, m_pre, m_val, m_en, m_tick, m_sel;
   longint unsigned m_leg;
   int m_sh [3];
   int m_code [NG], m_cnt [NG], m_str [NG];
   int terms [8] = '{1, 2, 5, 10, 100, 1000, 10000, 10000};

   task automatic model_reset();
      m_raw = 0; m_raw_w = 0; m_lpre = 0; m_leg = 0; m_pre = 0; m_val = 0;
      m_en = 0; m_tick = 0; m_sel = 0;
      for (int i = 0; i < 3; i++) m_sh[i] = 0;
      for (int i = 0; i < NG; i++) begin m_code[i] = 0; m_cnt[i] = 0; m_str[i] = 0; end
   endtask

   always @(posedge clk) begin
      if (rst) model_reset();
      else begin
         bit clr;
         int ntick;
         clr   = wr_en && wr_addr == 2'd1 && !wr_data[31];
         ntick = (m_en != 0 && ref_pulse && !clr && m_pre >= m_val) ? 1 : 0;
         if (clr) m_pre = 0;
         else if (m_en != 0 && ref_pulse) m_pre = (m_pre >= m_val) ? 0 : m_pre + 1;
         for (int i = 0; i < NG; i++) begin
            if (wr_en && wr_addr == 2'd2 && int'(wr_data[4*i +: 3]) != m_code[i]) begin
               m_cnt[i] = 0; m_str[i] = 0;
            end else if (m_tick != 0) begin
               if (m_cnt[i] == terms[m_code[i]] - 1) begin m_cnt[i] = 0; m_str[i] = 1; end
               else begin m_cnt[i]++; m_str[i] = 0; end
            end else m_str[i] = 0;
         end
         if (ref_pulse) begin
            m_raw = (m_raw + 1) & MASK56;
            m_raw_w = (m_raw_w + 1) % 256;
            if (m_lpre == LEG - 1) begin m_lpre = 0; m_leg = (m_leg + 1) & 64'hFFFF_FFFF; end
            else m_lpre++;
         end
         m_tick = ntick;
         if (wr_en) begin
            case (wr_addr)
               2'd0: begin
                  m_sh[0] = int'(wr_data[5:0]); m_sh[1] = int'(wr_data[11:6]);
                  m_sh[2] = int'(wr_data[17:12]); m_sel = int'(wr_data[18]);
               end
               2'd1: begin m_val = int'(wr_data[15:0]); m_en = int'(wr_data[31]); end
               2'd2: for (int i = 0; i < NG; i++) m_code[i] = int'(wr_data[4*i +: 3]);
               default: ;
            endcase
         end
      end
   end

   function automatic longint unsigned exp_stamp(int i);
      if (i == 0 && m_sel == 0) return m_leg;
      return (m_raw >> m_sh[i]) & 64'hFFFF_FFFF;
   endfunction

   task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (comparing && !rst) begin
         check(raw_time == m_raw[55:0], "R1", raw_time, m_raw);
         check(int'(raw_w) == m_raw_w, "R1 wrap", raw_w, m_raw_w);
         check(tag_stamp == exp_stamp(1), "R2 tag", tag_stamp, exp_stamp(1));
         check(nat_stamp == exp_stamp(2), "R2 nat", nat_stamp, exp_stamp(2));
         check(log_stamp == exp_stamp(0), "R3", log_stamp, exp_stamp(0));
         check(int'(common_tick) == m_tick, tick_req, common_tick, m_tick);
         for (int i = 0; i < NG; i++)
            check(int'(gen_tick[i]) == m_str[i], "R7/R8 gen", gen_tick[i], m_str[i]);
         if (raw_w == 8'd0 && raw_time != 0) wrap_seen = 1;
         if (common_tick) n_tick++;
         for (int i = 0; i < NG; i++) if (gen_tick[i]) n_gen[i]++;
      end
   end

   // reference pulse pattern
   always @(negedge clk) begin
      ref_phase = (ref_phase + 1) % 3;
      case (ref_mode)
         0: ref_pulse <= 1'b0;
         1: ref_pulse <= 1'b1;
         2: ref_pulse <= (ref_phase == 0);
         default: ref_pulse <= 1'($urandom_range(0, 1));
      endcase
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
      @(negedge clk);
      wr_en <= 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic latency(output int n);
      n = 0;
      while (!common_tick && n < 200) begin @(negedge clk); n++; end
   endtask

   task automatic gen_latency(int g, output int n);
      n = 0;
      while (!gen_tick[g] && n < 200) begin @(negedge clk); n++; end
   endtask

   function automatic logic [31:0] gran_word(int c0, int c1, int c2);
      return 32'(c0) | (32'(c1) << 4) | (32'(c2) << 8);
   endfunction

   initial begin
      int n;
      model_reset();
      rst = 1'b1;
      idle(4);
      // R9: reset state
      check(raw_time == 0 && log_stamp == 0 && tag_stamp == 0, "R9 stamps", raw_time, 0);
      check(common_tick == 0 && gen_tick == 0, "R9 ticks", {common_tick, gen_tick}, 0);
      @(negedge clk); rst <= 1'b0;
      comparing = 1;

      // R1/R3: legacy logging stamp with the divider still off (R9 leaves it disabled)
      ref_mode = 1; tick_req = "R9 divider off";
      idle(70);
      check(n_tick == 0, "R9 no tick", n_tick, 0);
      check(log_stamp == OUT_W'(raw_time / LEG), "R3 legacy", log_stamp, raw_time / LEG);

      // R2/R3: shifted stamps, sparse reference
      wr(2'd0, (32'd1 << 18) | (32'd5 << 12) | (32'd2 << 6) | 32'd3);
      ref_mode = 2; idle(60);
      check(tag_stamp == OUT_W'(raw_time >> 2), "R2 port", tag_stamp, raw_time >> 2);
      check(log_stamp == OUT_W'(raw_time >> 3), "R3 shifted", log_stamp, raw_time >> 3);

      // R4 + R6: enable divide-by-4 after clearing word
      ref_mode = 1; tick_req = "R4";
      wr(2'd1, 32'd3);
      wr(2'd1, 32'h8000_0003);
      latency(n);
      check(n == 4, "R6 first tick", n, 4);
      n_tick = 0; idle(80);
      check(n_tick == 20, "R4 rate", n_tick, 20);

      // R6: clearing write mid-period restarts the prescaler
      wr(2'd1, 32'h8000_0007);
      idle(5);
      wr(2'd1, 32'd7);
      wr(2'd1, 32'h8000_0007);
      tick_req = "R6";
      latency(n);
      check(n == 8, "R6 restart", n, 8);

      // R5: disabled divider is quiet
      tick_req = "R5";
      wr(2'd1, 32'd7);
      n_tick = 0; idle(60);
      check(n_tick == 0, "R5 quiet", n_tick, 0);

      // R7: generator rates with a tick every cycle
      tick_req = "R4";
      wr(2'd1, 32'h8000_0000);
      wr(2'd2, gran_word(0, 2, 3));
      idle(30);
      for (int i = 0; i < NG; i++) n_gen[i] = 0;
      idle(100);
      check(n_gen[0] == 100, "R7 code0", n_gen[0], 100);
      check(n_gen[1] == 20, "R7 code2", n_gen[1], 20);
      check(n_gen[2] == 10, "R7 code3", n_gen[2], 10);

      // R8: change only generator 1, time its restart
      wr(2'd2, gran_word(0, 3, 3));
      gen_latency(1, n);
      check(n == 10, "R8 restart", n, 10);
      idle(57);
      wr(2'd2, gran_word(1, 3, 3));
      idle(40);

      // R7: long granularities including code 7
      wr(2'd2, gran_word(4, 5, 7));
      idle(50);
      for (int i = 0; i < NG; i++) n_gen[i] = 0;
      idle(10000);
      check(n_gen[0] == 100, "R7 code4", n_gen[0], 100);
      check(n_gen[1] == 10, "R7 code5", n_gen[1], 10);
      check(n_gen[2] == 1, "R7 code7", n_gen[2], 1);

      // R4/R1: random reference with divider 2
      wr(2'd1, 32'd2);
      wr(2'd1, 32'h8000_0002);
      ref_mode = 3; idle(400);
      check(wrap_seen, "R1 wrap", wrap_seen, 1);

      // R9: reset mid-run
      comparing = 0;
      @(negedge clk); rst <= 1'b1;
      idle(2);
      check(raw_time == 0 && common_tick == 0 && gen_tick == 0, "R9 rerun", raw_time, 0);
      @(negedge clk); rst <= 1'b0;
      ref_mode = 1; idle(20);
      check(common_tick == 0 && log_stamp == OUT_W'(raw_time / LEG), "R9 disabled", common_tick, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule